// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block sends one low-speed USB packet onto the differential bus pins. A caller pulses `start` with a total byte count. The count includes the leading synchronisation byte, which the block generates itself. The remaining bytes come in one at a time on `in_data`. Each byte is consumed when `in_take` pulses, and the caller then presents the next one. Bits leave least significant first. They are NRZI encoded, and a stuff bit is inserted after every run of six ones. Each bit lasts a fixed number of clock cycles.

Before the first bit, the block holds the idle (J) level for one bit time with the drivers still off. It then enables the drivers and sends the bits. After the last bit it signals end of packet: both lines low for two bit times, then J for one bit time. It then turns the drivers off and leaves both pin levels low. When it releases the bus, it copies a pending device address into its active address register. It does this only for data packets, never for two-byte handshakes.

Choosing the PID, computing the CRC and deciding what to reply are left to the caller.

Top module: `usb_ls_tx`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and `pkt_len` lies in 2..12. Any other `start` is ignored: no output changes, no `in_take`, and a packet already in flight continues unchanged.
- R2: For the first bit time after an accepted start, the block drives `busy`=1, `oe`=0, `dp`=0 and `dm`=1 (J). The block then raises `oe`.
- R3: The bytes sent are 0x80 first, then exactly `pkt_len`-1 bytes from `in_data`. `in_take` pulses once for each byte consumed, one cycle after that byte was sampled.
- R4: Each byte is sent least significant bit first. A 0 bit toggles the line level and a 1 bit holds it. The level before the first bit is J.
- R5: After six consecutive 1 data bits, an extra toggle is inserted. The run of ones is counted across byte boundaries, including the sync byte, and the count restarts at zero for each packet. A stuff bit is still inserted if the run completes on the last bit.
- R6: After the last bit, the block drives `dp`=`dm`=0 with `oe`=1 for two bit times, then J for one bit time. It then drives `oe`=0 with `dp`=`dm`=0.
- R7: `busy` is high from the accepted start until the release of the bus. `done` pulses for exactly one cycle in the first cycle after release.
- R8: At release, `dev_addr` takes the value of `addr_new` when `pkt_len` was greater than 2. A two-byte packet leaves `dev_addr` unchanged. `dev_addr` resets to 0.
- R9: While driving, the J level is `dp`=0,`dm`=1 and the K level is `dp`=1,`dm`=0. `dp` and `dm` are never both high.
- R10: Every bit slot, including the preamble and end-of-packet slots, lasts exactly `CLKS_PER_BIT` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to send a packet |
| pkt_len | input | 4 | Total byte count including the sync byte, sampled at start |
| in_data | input | 8 | Next byte after the sync byte |
| in_take | output | 1 | Pulse: `in_data` has been consumed, present the next byte |
| addr_new | input | 7 | Pending device address |
| dev_addr | output | 7 | Active device address |
| dp | output | 1 | D+ level |
| dm | output | 1 | D- level |
| oe | output | 1 | Bus driver enable |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse at bus release |

## Verification
The hardest situation to reach is a stuffed bit whose run of ones straddles a byte boundary. The hardest case of all is a run that starts on the final 1 of the sync byte, or that completes on the last bit before end of packet. The stimulus reaches these cases with payloads chosen for them, such as 0x1F directly after the sync byte, long strings of 0xFF, and a final byte ending in six ones. A sweep over every legal length with varied bytes comes next. The bench predicts the line level in every cycle from its own model of the bit stream, so a slot that is one cycle short or long is caught. A start pulse with a bad length, given while a packet is in flight, confirms that the packet runs on undisturbed.

// File: rtl/usb_ls_tx_pkg.sv
// Shared types for the low-speed USB serializer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // drivers off
        ST_PREP,   // J held, drivers still off
        ST_DATA,   // NRZI bits on the bus
        ST_SE0,    // end of packet, both lines low
        ST_EOPJ    // end of packet, final J
    } tx_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;

endpackage

// File: rtl/usb_ls_bit_timer.sv
// Bit-period timer: divides the clock into bit slots of CLKS_PER_BIT
// cycles while run is high. tick marks the last cycle of each slot.
// Assumes run rises on the same edge the first slot begins.
module usb_ls_bit_timer #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Count cycles inside a slot, restart at each slot and when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/usb_ls_bit_source.sv
// Bit source with stuffing: holds the byte being sent and the run length
// of ones. It reports what the next symbol on the line must be (toggle or
// hold, or end of data). A step consumes that symbol. The caller keeps
// in_data valid until in_take pulses.
module usb_ls_bit_source #(
    parameter int MAX_BYTES = 12,
    parameter int STUFF_RUN = 6,
    localparam int LW = $clog2(MAX_BYTES + 1),
    localparam int OW = $clog2(STUFF_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] len,
    input  logic          step,
    input  logic [7:0]    in_data,
    output logic          nxt_toggle,
    output logic          nxt_end,
    output logic          take
);
    import usb_ls_tx_pkg::*;

    localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN);

    logic [7:0]    sh;
    logic [2:0]    bit_idx;
    logic [LW-1:0] bytes_left;
    logic          have_bits;
    logic [OW-1:0] ones;
    logic          take_q;
    logic          stuff_due;

    assign stuff_due  = (ones == RUN_MAX);
    assign nxt_end    = !stuff_due && !have_bits;
    assign nxt_toggle = stuff_due || !sh[0];
    assign take       = take_q;

    // Advance shifter, byte count and ones run on each consumed symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            bit_idx    <= '0;
            bytes_left <= '0;
            have_bits  <= 1'b0;
            ones       <= '0;
            take_q     <= 1'b0;
        end else begin
            take_q <= 1'b0;
            if (load) begin
                sh         <= SYNC_BYTE;
                bit_idx    <= '0;
                bytes_left <= len - 1'b1;
                have_bits  <= 1'b1;
                ones       <= '0;
            end else if (step) begin
                if (stuff_due) begin
                    ones <= '0;
                end else if (have_bits) begin
                    ones <= sh[0] ? ones + 1'b1 : '0;
                    if (bit_idx == 3'd7) begin
                        if (bytes_left != '0) begin
                            sh         <= in_data;
                            bytes_left <= bytes_left - 1'b1;
                            bit_idx    <= '0;
                            take_q     <= 1'b1;
                        end else begin
                            have_bits <= 1'b0;
                        end
                    end else begin
                        sh      <= {1'b0, sh[7:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/usb_ls_tx_ctrl.sv
// Packet sequencer: accepts a start and walks the phases (preamble J,
// data bits, end of packet). It keeps the NRZI level, drives the pins and
// commits the pending address at release. It assumes tick comes from a
// timer that runs whenever the sequencer is not idle.
module usb_ls_tx_ctrl #(
    parameter int MAX_BYTES = 12,
    parameter int MIN_BYTES = 2,
    parameter int HS_BYTES  = 2,
    parameter int SE0_BITS  = 2,
    parameter int ADDR_W    = 7,
    localparam int LW = $clog2(MAX_BYTES + 1),
    localparam int EW = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LW-1:0]     len,
    input  logic              tick,
    input  logic              nxt_toggle,
    input  logic              nxt_end,
    input  logic [ADDR_W-1:0] addr_new,
    output logic              load,
    output logic              step,
    output logic              run,
    output logic              dp,
    output logic              dm,
    output logic              oe,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] dev_addr
);
    import usb_ls_tx_pkg::*;

    localparam logic [LW-1:0] LEN_MIN = LW'(MIN_BYTES);
    localparam logic [LW-1:0] LEN_MAX = LW'(MAX_BYTES);
    localparam logic [LW-1:0] LEN_HS  = LW'(HS_BYTES);
    localparam logic [EW-1:0] SE0_END = EW'(SE0_BITS - 1);

    tx_state_t         state;
    logic              lvl_k;
    logic              is_hs;
    logic [EW-1:0]     se0_cnt;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic              len_ok;

    assign len_ok = (len >= LEN_MIN) && (len <= LEN_MAX);
    assign load   = (state == ST_IDLE) && start && len_ok;
    assign step   = tick && ((state == ST_PREP) || (state == ST_DATA));
    assign run    = (state != ST_IDLE);
    assign busy   = run;

    // Pin levels follow the phase and the NRZI level.
    always_comb begin
        oe = (state == ST_DATA) || (state == ST_SE0) || (state == ST_EOPJ);
        dp = (state == ST_DATA) && lvl_k;
        dm = (state == ST_PREP) || (state == ST_EOPJ) || ((state == ST_DATA) && !lvl_k);
    end

    // Phase sequencing and NRZI level update on slot boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lvl_k   <= 1'b0;
            is_hs   <= 1'b0;
            se0_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (load) begin
                    state <= ST_PREP;
                    lvl_k <= 1'b0;
                    is_hs <= (len == LEN_HS);
                end
                ST_PREP: if (tick) begin
                    state <= ST_DATA;
                    lvl_k <= lvl_k ^ nxt_toggle;
                end
                ST_DATA: if (tick) begin
                    if (nxt_end) begin
                        state   <= ST_SE0;
                        se0_cnt <= '0;
                    end else begin
                        lvl_k <= lvl_k ^ nxt_toggle;
                    end
                end
                ST_SE0: if (tick) begin
                    if (se0_cnt == SE0_END) begin
                        state <= ST_EOPJ;
                    end else begin
                        se0_cnt <= se0_cnt + 1'b1;
                    end
                end
                ST_EOPJ: if (tick) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Release pulse and address commit for data packets only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            addr_q <= '0;
        end else begin
            done_q <= (state == ST_EOPJ) && tick;
            if ((state == ST_EOPJ) && tick && !is_hs) begin
                addr_q <= addr_new;
            end
        end
    end

    assign done     = done_q;
    assign dev_addr = addr_q;
endmodule

// File: rtl/usb_ls_tx.sv
// Top of the low-speed USB serializer. It joins the bit timer, the bit
// source with stuffing and the packet sequencer. It assumes pkt_len and
// the first payload byte are valid when start is high.
module usb_ls_tx #(
    parameter int CLKS_PER_BIT = 8,
    parameter int MAX_BYTES    = 12,
    parameter int MIN_BYTES    = 2,
    parameter int HS_BYTES     = 2,
    parameter int STUFF_RUN    = 6,
    parameter int SE0_BITS     = 2,
    parameter int ADDR_W       = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [$clog2(MAX_BYTES + 1)-1:0] pkt_len,
    input  logic [7:0]                       in_data,
    output logic                             in_take,
    input  logic [ADDR_W-1:0]                addr_new,
    output logic [ADDR_W-1:0]                dev_addr,
    output logic                             dp,
    output logic                             dm,
    output logic                             oe,
    output logic                             busy,
    output logic                             done
);
    logic run;
    logic tick;
    logic load;
    logic step;
    logic nxt_toggle;
    logic nxt_end;

    usb_ls_bit_timer #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    usb_ls_bit_source #(
        .MAX_BYTES(MAX_BYTES),
        .STUFF_RUN(STUFF_RUN)
    ) source_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .len       (pkt_len),
        .step      (step),
        .in_data   (in_data),
        .nxt_toggle(nxt_toggle),
        .nxt_end   (nxt_end),
        .take      (in_take)
    );

    usb_ls_tx_ctrl #(
        .MAX_BYTES(MAX_BYTES),
        .MIN_BYTES(MIN_BYTES),
        .HS_BYTES (HS_BYTES),
        .SE0_BITS (SE0_BITS),
        .ADDR_W   (ADDR_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len       (pkt_len),
        .tick      (tick),
        .nxt_toggle(nxt_toggle),
        .nxt_end   (nxt_end),
        .addr_new  (addr_new),
        .load      (load),
        .step      (step),
        .run       (run),
        .dp        (dp),
        .dm        (dm),
        .oe        (oe),
        .busy      (busy),
        .done      (done),
        .dev_addr  (dev_addr)
    );
endmodule

// File: rtl/usb_ls_tx_chk.sv
// Property checker for the low-speed USB serializer, bound to every
// instance of the top. It observes ports only.
module usb_ls_tx_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dp,
    input logic              dm,
    input logic              oe,
    input logic              busy,
    input logic              done,
    input logic              in_take,
    input logic [ADDR_W-1:0] dev_addr
);
    // R9: the two lines are never high together
    a_r9_no_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp && dm));

    // R2: drivers turn on only after J was presented
    a_r2_j_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(dm && !dp));

    // R6: drivers turn off straight out of J, leaving both lines low
    a_r6_release_from_j: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> ($past(dm && !dp) && !dp && !dm));

    // R7: drivers are only on inside a busy packet
    a_r7_oe_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> busy);

    // R7: the end of busy coincides with the done pulse
    a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3: bytes are consumed only while bits are on the bus
    a_r3_take_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        in_take |-> oe);

    // R8: the active address changes only at release
    a_r8_addr_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> done);
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .dp      (dp),
    .dm      (dm),
    .oe      (oe),
    .busy    (busy),
    .done    (done),
    .in_take (in_take),
    .dev_addr(dev_addr)
);

// File: tb/tb_usb_ls_tx.sv
// Bench for the low-speed USB serializer. Every cycle of every packet is
// compared with a line model that the bench builds itself.
module tb_usb_ls_tx;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] pkt_len = '0;
    logic [7:0] in_data;
    logic       in_take;
    logic [6:0] addr_new = '0;
    logic [6:0] dev_addr;
    logic       dp, dm, oe, busy, done;

    logic [7:0] tx_bytes [0:15];
    int         byte_idx = 0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;

    bit         exp_lvl   [0:199];
    bit         exp_stuff [0:199];
    int         nsym;

    always #4 clk = ~clk;

    assign in_data = tx_bytes[byte_idx[3:0]];

    usb_ls_tx #(.CLKS_PER_BIT(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len),
        .in_data(in_data), .in_take(in_take), .addr_new(addr_new),
        .dev_addr(dev_addr), .dp(dp), .dm(dm), .oe(oe), .busy(busy),
        .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Build the expected line levels (1 = K) for a packet of len bytes.
    task automatic build(input int len);
        bit lvl = 0;
        int ones = 0;
        nsym = 0;
        for (int b = 0; b < len; b++) begin
            logic [7:0] v = (b == 0) ? 8'h80 : tx_bytes[b-1];
            for (int i = 0; i < 8; i++) begin
                if (v[i] == 1'b0) begin lvl = ~lvl; ones = 0; end
                else ones++;
                exp_lvl[nsym] = lvl; exp_stuff[nsym] = 0; nsym++;
                if (ones == 6) begin
                    lvl = ~lvl; ones = 0;
                    exp_lvl[nsym] = lvl; exp_stuff[nsym] = 1; nsym++;
                end
            end
        end
    endtask

    // Send one packet and compare every cycle. inject_at > 0 gives a
    // stray start with length inject_len in that cycle.
    task automatic run_packet(input int len, input int inject_at, input int inject_len);
        int takes = 0;
        int dones = 0;
        int total;
        logic [6:0] old_addr = dev_addr;
        logic [6:0] want_addr;
        build(len);
        byte_idx = 0;
        total = N * (nsym + 6);
        start = 1'b1;
        pkt_len = 4'(len);
        for (int m = 1; m <= total; m++) begin
            int slot;
            bit e_busy, e_oe, e_dp, e_dm;
            string tag;
            @(negedge clk);
            if (m == 1) start = 1'b0;
            if (m == inject_at) begin start = 1'b1; pkt_len = 4'(inject_len); end
            if (m == inject_at + 1) start = 1'b0;
            if (in_take) begin takes++; byte_idx++; end
            if (done) begin
                dones++;
                chk(m == N * (nsym + 4) + 1, "R7 done cycle", m, N * (nsym + 4) + 1);
            end
            slot = (m - 1) / N;
            if (slot == 0) begin
                e_busy = 1; e_oe = 0; e_dp = 0; e_dm = 1; tag = "R2 preamble";
            end else if (slot <= nsym) begin
                e_busy = 1; e_oe = 1; e_dp = exp_lvl[slot-1]; e_dm = !exp_lvl[slot-1];
                tag = exp_stuff[slot-1] ? "R5 stuff bit" : "R4 R9 data bit";
            end else if (slot <= nsym + 2) begin
                e_busy = 1; e_oe = 1; e_dp = 0; e_dm = 0; tag = "R6 se0";
            end else if (slot == nsym + 3) begin
                e_busy = 1; e_oe = 1; e_dp = 0; e_dm = 1; tag = "R6 final J";
            end else begin
                e_busy = 0; e_oe = 0; e_dp = 0; e_dm = 0;
                tag = (inject_at > 0) ? "R1 R6 R7 released" : "R6 R7 released";
            end
            if ((m - 1) % N == 0) tag = {tag, " R10"};
            chk({busy, oe, dp, dm} == {e_busy, e_oe, e_dp, e_dm}, tag,
                {busy, oe, dp, dm}, {e_busy, e_oe, e_dp, e_dm});
        end
        chk(takes == len - 1, "R3 bytes taken", takes, len - 1);
        chk(dones == 1, "R7 done count", dones, 1);
        want_addr = (len > 2) ? addr_new : old_addr;
        chk(dev_addr == want_addr, "R8 address commit", dev_addr, want_addr);
    endtask

    // A start with an illegal length must leave the block idle.
    task automatic try_bad(input int len);
        int takes = 0;
        start = 1'b1;
        pkt_len = 4'(len);
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m < 3 * N; m++) begin
            @(negedge clk);
            if (in_take || busy || oe || dp || dm || done) takes++;
        end
        chk(takes == 0, "R1 bad length ignored", takes, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) tx_bytes[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, oe, dp, dm, done} == 5'b0, "R7 reset outputs", {busy, oe, dp, dm, done}, 0);
        chk(dev_addr == 7'h00, "R8 reset address", dev_addr, 0);

        // R8: handshakes must not commit the address
        addr_new = 7'h15; tx_bytes[0] = 8'hD2;
        run_packet(2, 0, 0);
        addr_new = 7'h2A; tx_bytes[0] = 8'h5A;
        run_packet(2, 0, 0);

        // R5: run of ones starting on the sync byte's last bit
        addr_new = 7'h33; tx_bytes[0] = 8'h1F; tx_bytes[1] = 8'h00;
        run_packet(3, 0, 0);

        // R5: stuffing across byte boundaries and on the final bit
        addr_new = 7'h41;
        for (int i = 0; i < 11; i++) tx_bytes[i] = 8'hFF;
        run_packet(12, 9 * N, 5);

        addr_new = 7'h07; tx_bytes[0] = 8'h00; tx_bytes[1] = 8'hFC;
        run_packet(3, 5 * N, 1);

        // R1: illegal lengths
        try_bad(0); try_bad(1); try_bad(13); try_bad(15);

        // Sweep every legal length with varied payloads (R3 R4 R5 R8)
        for (int len = 2; len <= 12; len++) begin
            for (int i = 0; i < 11; i++) tx_bytes[i] = 8'((i * 37 + len * 11) ^ (i << 5));
            tx_bytes[len - 2] = 8'hFC;
            addr_new = 7'(len * 9 + 1);
            run_packet(len, 0, 0);
        end
        for (int len = 2; len <= 12; len++) begin
            for (int i = 0; i < 11; i++) tx_bytes[i] = (i % 2 == 0) ? 8'h7E : 8'hBF;
            addr_new = 7'(len * 5 + 3);
            run_packet(len, 0, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule